// File: doc/BRIEF.md
# Bank-Group DRAM Command Scheduler

This block sits in a DRAM memory controller between the request path and the device command bus. The device has no write buffer. Its banks fall into two groups: the even group and the odd group. Bit 0 of the bank address selects the group. Write data goes straight into the array. The scheduler therefore hides the write-to-read turnaround itself. A read to the group opposite a write in flight may issue at once, so its data phase overlaps the tail of the write burst. A read to the same group waits for the write burst plus a turnaround gap.

Requests arrive on a valid/ready interface and carry a direction, a bank, a row and a column. They wait in a small queue whose slot 0 always holds the oldest entry. Each cycle the scheduler picks the oldest entry that may legally take a step and issues exactly one command on the shared bus. A step is a precharge, an activate, or the final read or write. The block keeps an open-row register and a valid flag for each bank, and per-bank countdown timers for activate-to-column and precharge-to-activate. Each column command moves one full burst. This burst occupies a fixed number of data-bus cycles whatever the configured device width.

Top module: `bankset_sched`

## Requirements
- R1: After reset no command is issued (cmd_valid low), every bank is closed, and req_ready is high.
- R2: A request to a closed bank first issues ACTIVATE (cmd_code 0) with its row, then its column command (READ = 2, WRITE = 3). The column command comes exactly T_RCD cycles after the activate when nothing else blocks it.
- R3: A request to a bank holding a different open row issues PRECHARGE (cmd_code 1), then ACTIVATE T_RP cycles later, then the column command T_RCD cycles after that. A precharge is only ever sent to an open bank.
- R4: A request whose row is already open in its bank issues only its column command, with no row command.
- R5: A read whose bank group (bank bit 0) matches that of an earlier write issues no sooner than BURST_CYC + T_WTR cycles after that write command.
- R6: A read to the opposite bank group of an in-flight write is not held by turnaround. It issues in the next free command slot.
- R7: Each cycle the oldest queue entry whose constraints are met is served. A younger opposite-group read passes an older same-group read that is blocked by turnaround. Row commands for a bank are reserved for the oldest queued request to that bank.
- R8: Two requests to the same bank, row and column, at least one of them a write, issue their column commands in arrival order. A read never passes an older write to that address, and a write never passes an older read to it.
- R9: At most one command issues per cycle. Every command respects the per-bank T_RCD and T_RP counts and the per-group write-to-read gap.
- R10: The queue holds QDEPTH requests. req_ready is low while it is full, and it rises again after a column command frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank address; bit 0 selects the group |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_code | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column (column commands) |

## Verification
The bench measures the write-to-read gap for a read to the same group and for a read to the opposite group. A design that ignored the group would either delay both reads or let the same-group read through early. It queues a blocked same-group read in front of an opposite-group read. A strictly in-order design would then serve them in the wrong order. A read placed between a write and a younger write to the same address would let a design missing the address hazard reorder the two. A reference bank model watches every command for activates to open banks, precharges to closed banks, early column commands, early reads and overflow of a full queue.

// File: rtl/bankset_sched.sv
module bankset_sched #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int QDEPTH    = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  parameter int BURST_CYC = 2,
  parameter int T_WTR     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  localparam int NBANK = 1 << BANK_W;
  localparam int QW    = $clog2(QDEPTH + 1);
  localparam int QI    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int TW    = $clog2(BURST_CYC + T_WTR + T_RCD + T_RP + 1);
  localparam logic [1:0] C_ACT = 2'd0, C_PRE = 2'd1, C_RD = 2'd2, C_WR = 2'd3;

  logic [QDEPTH-1:0] q_v, q_w, n_v, n_w;
  logic [BANK_W-1:0] q_b [QDEPTH];
  logic [BANK_W-1:0] n_b [QDEPTH];
  logic [ROW_W-1:0]  q_r [QDEPTH];
  logic [ROW_W-1:0]  n_r [QDEPTH];
  logic [COL_W-1:0]  q_c [QDEPTH];
  logic [COL_W-1:0]  n_c [QDEPTH];
  logic [QW-1:0]     q_cnt, n_cnt;

  logic [NBANK-1:0]  row_vld;
  logic [ROW_W-1:0]  open_row [NBANK];
  logic [TW-1:0]     bank_tmr [NBANK];
  logic [TW-1:0]     wtr_cnt [2];

  logic              found;
  logic [QI-1:0]     pk_idx;
  logic [1:0]        pk_op;
  logic              rm, push;

  assign req_ready = (q_cnt != QW'(QDEPTH));
  assign push      = req_valid && req_ready;
  assign rm        = found && pk_op[1];

  always_comb begin
    found  = 1'b0;
    pk_idx = '0;
    pk_op  = C_ACT;
    for (int i = 0; i < QDEPTH; i++) begin
      logic older_bank, haz, hit, ok;
      logic [1:0] op;
      older_bank = 1'b0;
      haz = 1'b0;
      ok  = 1'b0;
      op  = C_ACT;
      for (int j = 0; j < QDEPTH; j++) begin
        if (j < i && q_v[j] && q_b[j] == q_b[i]) begin
          older_bank = 1'b1;
          if (q_r[j] == q_r[i] && q_c[j] == q_c[i] && (q_w[j] || q_w[i])) haz = 1'b1;
        end
      end
      hit = row_vld[q_b[i]] && open_row[q_b[i]] == q_r[i];
      if (bank_tmr[q_b[i]] == '0) begin
        if (hit) begin
          op = q_w[i] ? C_WR : C_RD;
          ok = !haz && (q_w[i] || wtr_cnt[q_b[i][0]] == '0);
        end else if (!older_bank) begin
          op = row_vld[q_b[i]] ? C_PRE : C_ACT;
          ok = 1'b1;
        end
      end
      if (q_v[i] && ok && !found) begin
        found  = 1'b1;
        pk_idx = QI'(i);
        pk_op  = op;
      end
    end
  end

  always_comb begin
    logic [QW-1:0] tail;
    for (int i = 0; i < QDEPTH; i++) begin
      int src;
      src = (rm && i >= int'(pk_idx)) ? i + 1 : i;
      if (src < QDEPTH) begin
        n_v[i] = q_v[src]; n_w[i] = q_w[src];
        n_b[i] = q_b[src]; n_r[i] = q_r[src]; n_c[i] = q_c[src];
      end else begin
        n_v[i] = 1'b0; n_w[i] = 1'b0;
        n_b[i] = '0; n_r[i] = '0; n_c[i] = '0;
      end
    end
    tail = q_cnt - QW'(rm);
    if (push) begin
      n_v[tail] = 1'b1; n_w[tail] = req_write;
      n_b[tail] = req_bank; n_r[tail] = req_row; n_c[tail] = req_col;
    end
    n_cnt = tail + QW'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= '0; q_w <= '0; q_cnt <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_b[i] <= '0; q_r[i] <= '0; q_c[i] <= '0;
      end
      row_vld <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] <= '0; bank_tmr[b] <= '0;
      end
      wtr_cnt[0] <= '0; wtr_cnt[1] <= '0;
      cmd_valid <= 1'b0; cmd_code <= '0; cmd_bank <= '0; cmd_row <= '0; cmd_col <= '0;
    end else begin
      q_v <= n_v; q_w <= n_w; q_cnt <= n_cnt;
      for (int i = 0; i < QDEPTH; i++) begin
        q_b[i] <= n_b[i]; q_r[i] <= n_r[i]; q_c[i] <= n_c[i];
      end
      for (int b = 0; b < NBANK; b++)
        if (bank_tmr[b] != '0) bank_tmr[b] <= bank_tmr[b] - 1'b1;
      for (int s = 0; s < 2; s++)
        if (wtr_cnt[s] != '0) wtr_cnt[s] <= wtr_cnt[s] - 1'b1;
      if (found) begin
        case (pk_op)
          C_ACT: begin
            row_vld[q_b[pk_idx]]  <= 1'b1;
            open_row[q_b[pk_idx]] <= q_r[pk_idx];
            bank_tmr[q_b[pk_idx]] <= TW'(T_RCD - 1);
          end
          C_PRE: begin
            row_vld[q_b[pk_idx]]  <= 1'b0;
            bank_tmr[q_b[pk_idx]] <= TW'(T_RP - 1);
          end
          C_WR:    wtr_cnt[q_b[pk_idx][0]] <= TW'(BURST_CYC + T_WTR - 1);
          default: ;
        endcase
      end
      cmd_valid <= found;
      cmd_code  <= pk_op;
      cmd_bank  <= q_b[pk_idx];
      cmd_row   <= q_r[pk_idx];
      cmd_col   <= q_c[pk_idx];
    end
  end

  a_r2_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_ACT) |->
      (($past(row_vld) & (NBANK'(1) << cmd_bank)) == '0) && row_vld[cmd_bank]);

  a_r3_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_PRE) |->
      (($past(row_vld) & (NBANK'(1) << cmd_bank)) != '0) && !row_vld[cmd_bank]);

  a_r4_col_row_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[1]) |-> row_vld[cmd_bank] && open_row[cmd_bank] == cmd_row);

  a_r5_no_back_to_back_same_group: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_RD) |->
      !($past(cmd_valid && cmd_code == C_WR) && $past(cmd_bank[0]) == cmd_bank[0]));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(QDEPTH));
endmodule

// File: tb/bankset_sched_tb_top.sv
module bankset_sched_tb_top;
  localparam int BANK_W = 2, ROW_W = 8, COL_W = 6, QDEPTH = 4;
  localparam int T_RCD = 3, T_RP = 2, BURST_CYC = 2, T_WTR = 4;
  localparam int NB = 1 << BANK_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ready, cmd_valid;
  logic [1:0] cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  bankset_sched #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .QDEPTH(QDEPTH),
    .T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST_CYC), .T_WTR(T_WTR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col));

  always #10 clk = ~clk;

  int total = 0, bad = 0, viol = 0, cyc = 0, nlog = 0;
  int lg_t [512]; int lg_c [512]; int lg_b [512]; int lg_r [512]; int lg_col [512];
  int m_open [NB]; int m_row [NB]; int m_act [NB]; int m_pre [NB]; int m_wr [2];

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_act[b] = -1000; m_pre[b] = -1000; end
    m_wr[0] = -1000; m_wr[1] = -1000;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && cmd_valid) begin
    int b;
    b = int'(cmd_bank);
    if (nlog < 512) begin
      lg_t[nlog] = cyc; lg_c[nlog] = int'(cmd_code); lg_b[nlog] = b;
      lg_r[nlog] = int'(cmd_row); lg_col[nlog] = int'(cmd_col); nlog++;
    end
    case (cmd_code)
      2'd0: begin
        if (m_open[b] != 0 || cyc - m_pre[b] < T_RP) begin viol++; $display("model violation: activate bank %0d at %0d", b, cyc); end
        m_open[b] = 1; m_row[b] = int'(cmd_row); m_act[b] = cyc;
      end
      2'd1: begin
        if (m_open[b] == 0 || cyc - m_act[b] < T_RCD) begin viol++; $display("model violation: precharge bank %0d at %0d", b, cyc); end
        m_open[b] = 0; m_pre[b] = cyc;
      end
      default: begin
        if (m_open[b] == 0 || m_row[b] != int'(cmd_row) || cyc - m_act[b] < T_RCD) begin
          viol++; $display("model violation: column bank %0d at %0d", b, cyc);
        end
        if (cmd_code == 2'd2 && cyc - m_wr[b % 2] < BURST_CYC + T_WTR) begin
          viol++; $display("model violation: early read bank %0d at %0d", b, cyc);
        end
        if (cmd_code == 2'd3) m_wr[b % 2] = cyc;
      end
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic send(input bit w, input int b, input int r, input int c);
    req_valid = 1'b1; req_write = w;
    req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int find(input int code, input int b, input int c, input int from);
    for (int k = from; k < nlog; k++)
      if (lg_c[k] == code && lg_b[k] == b && (c < 0 || lg_col[k] == c)) return k;
    return -1;
  endfunction

  task automatic t_reset;
    bit quiet = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (cmd_valid) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R1 no command after reset", int'(quiet), 1);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_closed_bank;
    int m = nlog;
    send(1, 0, 5, 1); idle(15);
    check(nlog - m == 2, "R2 closed bank command count", nlog - m, 2);
    check(lg_c[m] == 0 && lg_b[m] == 0 && lg_r[m] == 5, "R2 activate first", lg_c[m], 0);
    check(lg_c[m+1] == 3 && lg_col[m+1] == 1, "R2 write follows", lg_c[m+1], 3);
    check(lg_t[m+1] - lg_t[m] == T_RCD, "R2 activate-to-column gap", lg_t[m+1] - lg_t[m], T_RCD);
  endtask

  task automatic t_row_hit;
    int m = nlog;
    send(1, 0, 5, 2); idle(15);
    check(nlog - m == 1, "R4 hit issues single command", nlog - m, 1);
    check(lg_c[m] == 3 && lg_col[m] == 2, "R4 hit is write", lg_c[m], 3);
  endtask

  task automatic t_row_miss;
    int m = nlog;
    send(0, 0, 9, 0); idle(15);
    check(nlog - m == 3, "R3 miss command count", nlog - m, 3);
    check(lg_c[m] == 1 && lg_c[m+1] == 0 && lg_c[m+2] == 2, "R3 precharge, activate, read", lg_c[m] * 100 + lg_c[m+1] * 10 + lg_c[m+2], 102);
    check(lg_t[m+1] - lg_t[m] == T_RP, "R3 precharge-to-activate gap", lg_t[m+1] - lg_t[m], T_RP);
    check(lg_t[m+2] - lg_t[m+1] == T_RCD, "R3 activate-to-read gap", lg_t[m+2] - lg_t[m+1], T_RCD);
  endtask

  task automatic t_groups;
    int m, w, r, gs, go;
    send(0, 1, 3, 0); send(0, 2, 4, 0); idle(20);
    m = nlog;
    send(1, 0, 9, 3); send(0, 2, 4, 5); idle(20);
    w = find(3, 0, 3, m); r = find(2, 2, 5, m);
    gs = (w >= 0 && r >= 0) ? lg_t[r] - lg_t[w] : -1;
    check(gs == BURST_CYC + T_WTR, "R5 same-group read gap", gs, BURST_CYC + T_WTR);
    m = nlog;
    send(1, 0, 9, 4); send(0, 1, 3, 6); idle(20);
    w = find(3, 0, 4, m); r = find(2, 1, 6, m);
    go = (w >= 0 && r >= 0) ? lg_t[r] - lg_t[w] : -1;
    check(go == 1, "R6 opposite-group read gap", go, 1);
    check(go >= 0 && go < gs, "R6 opposite group finishes earlier", go, gs);
  endtask

  task automatic t_bypass;
    int m, w, rs, ro;
    m = nlog;
    send(1, 0, 9, 7); send(0, 2, 4, 8); send(0, 1, 3, 9); idle(20);
    w = find(3, 0, 7, m); rs = find(2, 2, 8, m); ro = find(2, 1, 9, m);
    check(ro >= 0 && rs >= 0 && ro < rs, "R7 younger opposite read passes", ro, rs);
    check(rs >= 0 && w >= 0 && lg_t[rs] - lg_t[w] == BURST_CYC + T_WTR, "R7 blocked read waits",
          (rs >= 0 && w >= 0) ? lg_t[rs] - lg_t[w] : -1, BURST_CYC + T_WTR);
  endtask

  task automatic t_same_addr;
    int m, w1, r, w2;
    m = nlog;
    send(1, 0, 9, 1); send(0, 2, 4, 11); send(1, 2, 4, 11); idle(20);
    w1 = find(3, 0, 1, m); r = find(2, 2, 11, m); w2 = find(3, 2, 11, m);
    check(r >= 0 && w2 > r, "R8 write stays behind older read", w2, r + 1);
    check(w1 >= 0 && w1 < r, "R8 first write leads", w1, 0);
  endtask

  task automatic t_full;
    int m;
    bit in_order = 1'b1;
    m = nlog;
    send(1, 0, 9, 30);
    for (int k = 0; k < 4; k++) send(0, 0, 9, 20 + k);
    check(req_ready == 1'b0, "R10 ready low when full", int'(req_ready), 0);
    send(0, 0, 9, 24); idle(25);
    for (int k = 0; k < 5; k++) begin
      int a;
      a = find(2, 0, 20 + k, m);
      if (a != m + 1 + k) in_order = 1'b0;
    end
    check(in_order, "R7 queued reads served oldest first", int'(in_order), 1);
    check(nlog - m == 6, "R10 all requests drain", nlog - m, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_closed_bank;
    t_row_hit;
    t_row_miss;
    t_groups;
    t_bypass;
    t_same_addr;
    t_full;
    check(viol == 0, "R9 bank model timing violations", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule